// File: doc/BRIEF.md
# Shift Register with Storage Loop

This block pairs a serial shift register with a storage register of the same width, joined so that data can move between them in parallel in either direction. A single serial pin serves both directions. It is modelled as a data input, a data output and an output enable. In write mode, bits arrive on the serial input and enter the top of the shift register. In read mode, the lowest bit is driven out and fed back into the top, so reading a full word leaves it unchanged.

The storage register can capture the live shift-register contents and presents them on a parallel output. The shift register can in turn be refilled from the storage register. An active-low chip select acts as a clock enable for both registers and releases the serial output. An active-low asynchronous store clear empties the storage register at any time, whether or not the chip is selected. A synchronous active-high reset clears both registers.

Top module: `shift_store_loop`

## Requirements
- R1: With `rst` high at a rising clock edge, both the shift register and the storage register become zero, so `par_q` and `ser_o` read 0 after that edge.
- R2: With the chip selected (`cs_n`=0), `shift_en`=1, `reload`=0 and `rd_mode`=0, each edge moves the shift register one place toward bit 0 and places `ser_i` in bit 15.
- R3: With the chip selected, `shift_en`=1, `reload`=0 and `rd_mode`=1, each edge moves the word toward bit 0 and copies the old bit 0 into bit 15. `ser_o` always shows bit 0, and after 16 such shifts the word is unchanged.
- R4: With the chip selected, `store_en`=1 and `clr_n`=1 at an edge, the storage register takes the shift-register value present before that edge, even when the shift register changes on the same edge. `par_q` shows the storage register.
- R5: With the chip selected and `reload`=1, the shift register takes the storage-register value at the edge, and `shift_en` has no effect on that cycle.
- R6: With `reload`=1 and `store_en`=1 on the same edge, the two registers exchange contents.
- R7: With `cs_n`=1, no edge changes either register, whatever the enables are, and `ser_oe` is 0.
- R8: With `clr_n`=0, `par_q` becomes 0 at once, without waiting for a clock edge, and the chip select does not block it. A clear present at an edge overrides a capture, and the shift register is not touched.
- R9: `ser_oe` is 1 exactly when the chip is selected and `rd_mode`=1. It is 0 in write mode.
- R10: With the chip selected and `shift_en`, `reload` and `store_en` all 0, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; acts as a clock enable |
| clr_n | input | 1 | Asynchronous storage clear, active low |
| shift_en | input | 1 | Shift the shift register by one place |
| rd_mode | input | 1 | 1 = read (recirculate, drive out), 0 = write (serial entry) |
| reload | input | 1 | Load the shift register from the storage register |
| store_en | input | 1 | Capture the shift register into the storage register |
| ser_i | input | 1 | Serial data in (pin input side) |
| ser_o | output | 1 | Serial data out, bit 0 of the shift register |
| ser_oe | output | 1 | Serial pin drive enable |
| par_q | output | 16 | Storage register contents |

## Verification
Capture into storage and refill of the shift register can land on the same edge. Capture can also coincide with a shift. The bench drives store with reload, and store with shift, on one cycle after loading the two registers with different words. It then compares the exchanged or pre-shift values against its reference model on the following cycles. An asynchronous clear is also raised on a cycle that requests a capture, to judge that the clear wins.

// File: rtl/shl_pkg.sv
package shl_pkg;

    localparam int unsigned SHL_DEFAULT_W = 16;

    typedef enum logic [1:0] {
        SH_HOLD      = 2'd0,
        SH_SERIAL_IN = 2'd1,
        SH_RECIRC    = 2'd2,
        SH_RELOAD    = 2'd3
    } shift_op_e;

    typedef struct packed {
        shift_op_e op;
        logic      capture;
        logic      drive;
    } shl_ctrl_t;

    // Refill wins over shifting; chip select gates every register update.
    function automatic shl_ctrl_t shl_decode(
        input logic cs_n,
        input logic shift_en,
        input logic rd_mode,
        input logic reload,
        input logic store_en
    );
        shl_ctrl_t c;
        c.op      = SH_HOLD;
        c.capture = 1'b0;
        c.drive   = 1'b0;
        if (!cs_n) begin
            if (reload)
                c.op = SH_RELOAD;
            else if (shift_en)
                c.op = rd_mode ? SH_RECIRC : SH_SERIAL_IN;
            c.capture = store_en;
            c.drive   = rd_mode;
        end
        return c;
    endfunction

endpackage

// File: rtl/shl_ctrl.sv
module shl_ctrl
    import shl_pkg::*;
(
    input  logic      cs_n,
    input  logic      shift_en,
    input  logic      rd_mode,
    input  logic      reload,
    input  logic      store_en,
    output shl_ctrl_t ctrl
);

    always_comb begin
        ctrl = shl_decode(cs_n, shift_en, rd_mode, reload, store_en);
    end

endmodule

// File: rtl/shl_shifter.sv
module shl_shifter
    import shl_pkg::*;
#(
    parameter int unsigned W = SHL_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_op_e    op,
    input  logic         ser_i,
    input  logic [W-1:0] load_d,
    output logic [W-1:0] q
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] nxt;
    logic         top_bit;

    always_comb begin
        top_bit = (op == SH_RECIRC) ? q[0] : ser_i;
    end

    always_comb begin
        unique case (op)
            SH_SERIAL_IN,
            SH_RECIRC:  nxt = {top_bit, q[MSB:1]};
            SH_RELOAD:  nxt = load_d;
            default:    nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/shl_store.sv
module shl_store #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else if (rst)
            q <= '0;
        else if (capture)
            q <= d;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (q == '0)); // R8

    AST_CLEAR_BEATS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && capture) |=> (q == '0 || clr_n)); // R8

endmodule

// File: rtl/shift_store_loop.sv
module shift_store_loop
    import shl_pkg::*;
#(
    parameter int unsigned W = SHL_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         clr_n,
    input  logic         shift_en,
    input  logic         rd_mode,
    input  logic         reload,
    input  logic         store_en,
    input  logic         ser_i,
    output logic         ser_o,
    output logic         ser_oe,
    output logic [W-1:0] par_q
);

    localparam int unsigned MSB = W - 1;

    shl_ctrl_t    ctrl;
    logic [W-1:0] shift_q;
    logic [W-1:0] store_q;

    shl_ctrl u_ctrl (
        .cs_n     (cs_n),
        .shift_en (shift_en),
        .rd_mode  (rd_mode),
        .reload   (reload),
        .store_en (store_en),
        .ctrl     (ctrl)
    );

    shl_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .op     (ctrl.op),
        .ser_i  (ser_i),
        .load_d (store_q),
        .q      (shift_q)
    );

    shl_store #(.W(W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n),
        .capture (ctrl.capture),
        .d       (shift_q),
        .q       (store_q)
    );

    assign ser_o  = shift_q[0];
    assign ser_oe = ctrl.drive;
    assign par_q  = store_q;

    AST_WRITE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && shift_en && !reload && !rd_mode) |=>
            (shift_q == {$past(ser_i), $past(shift_q[MSB:1])})); // R2

    AST_READ_RECIRC: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && shift_en && !reload && rd_mode) |=>
            (shift_q == {$past(shift_q[0]), $past(shift_q[MSB:1])})); // R3

    AST_RELOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && reload) |=> (shift_q == $past(store_q))); // R5

    AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && clr_n) |=> ($stable(shift_q) && (!clr_n || $stable(store_q)))); // R7

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !ser_oe); // R7

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !rd_mode |-> !ser_oe); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !shift_en && !reload && !store_en && clr_n) |=>
            ($stable(shift_q) && (!clr_n || $stable(store_q)))); // R10

endmodule

// File: tb/shift_store_loop_test.sv
`timescale 1ns/1ps
module shift_store_loop_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1;
    logic         clr_n = 1'b1;
    logic         shift_en = 1'b0;
    logic         rd_mode = 1'b0;
    logic         reload = 1'b0;
    logic         store_en = 1'b0;
    logic         ser_i = 1'b0;
    logic         ser_o;
    logic         ser_oe;
    logic [W-1:0] par_q;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    logic [W-1:0] m_sh = '0;
    logic [W-1:0] m_st = '0;

    always #10 clk = ~clk;

    shift_store_loop #(.W(W)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .clr_n(clr_n),
        .shift_en(shift_en), .rd_mode(rd_mode), .reload(reload),
        .store_en(store_en), .ser_i(ser_i), .ser_o(ser_o),
        .ser_oe(ser_oe), .par_q(par_q)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        logic [W-1:0] nsh;
        logic [W-1:0] nst;
        if (rst) begin
            m_sh = '0;
            m_st = '0;
        end else begin
            nsh = m_sh;
            nst = m_st;
            if (!cs_n) begin
                if (reload)
                    nsh = m_st;
                else if (shift_en)
                    nsh = {(rd_mode ? m_sh[0] : ser_i), m_sh[W-1:1]};
                if (store_en)
                    nst = m_sh;
            end
            if (!clr_n)
                nst = '0;
            m_sh = nsh;
            m_st = nst;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_req, "par_q", par_q, m_st);
        check(cur_req, "ser_o", {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, m_sh[0]});
        check((cur_req == "R7") ? "R7" : "R9", "ser_oe",
              {{(W-1){1'b0}}, ser_oe}, {{(W-1){1'b0}}, (!cs_n && rd_mode)});
    endtask

    // Apply inputs just after a falling edge; compare at the next falling edge.
    task automatic cyc(input logic cs, input logic sh, input logic rd,
                       input logic rl, input logic st, input logic si,
                       input string req);
        cs_n = cs; shift_en = sh; rd_mode = rd; reload = rl;
        store_en = st; ser_i = si; cur_req = req;
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] pat;
        logic [W-1:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        compare_all();

        // R2: serial write of a word, ser_oe must stay low (R9)
        pat = 16'hA5C3;
        for (int i = 0; i < W; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pat[i], "R2");
        // R4: capture the written word
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        check("R2", "written word", par_q, pat);

        // R3: full-word read recirculates; capture afterwards shows same word
        for (int i = 0; i < W; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        check("R3", "word after read", par_q, pat);

        // R4: capture and shift on one edge -> pre-shift value stored
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

        // R5: change shift reg, then reload with shift_en also high
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");

        // R6: make registers differ, then store+reload together
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        for (int i = 0; i < W; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");

        // R7: deselected, every enable high
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");

        // R10: selected but idle
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10");

        // R8: asynchronous clear while deselected, seen before any edge
        cs_n = 1'b1; clr_n = 1'b0; m_st = '0;
        #3;
        check("R8", "async clear deselected", par_q, '0);
        @(negedge clk);
        cur_req = "R8";
        compare_all();
        clr_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        // clear held across an edge that requests capture: clear wins
        cs_n = 1'b0; store_en = 1'b1; clr_n = 1'b0; m_st = '0;
        #3;
        check("R8", "async clear selected", par_q, '0);
        @(negedge clk);
        cur_req = "R8";
        compare_all();
        clr_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

        // Mixed pattern from an LFSR
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[W-1:1]};
            cyc(lfsr[0] & lfsr[7], lfsr[1], lfsr[2], lfsr[3] & lfsr[9],
                lfsr[4] & lfsr[11], lfsr[5], "R6");
        end

        // R1: synchronous reset clears both registers
        rst = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        check("R1", "par_q after reset", par_q, '0);

        finish_run();
    end

endmodule